// File: doc/BRIEF.md
# Load/Store Address Offset Generator

This block turns the addressing fields of a single-register load or store instruction word into the numbers the memory stage needs. It takes three operands: the base register value, the offset register value and the current carry flag. From these it forms an offset. The offset is either a 12-bit unsigned immediate or a register passed through a shifter whose amount is held in the instruction. The offset is added to or subtracted from the base. The block then reports the access address, the value to write back to the base register, whether that write happens, the transfer direction, the transfer size and the base register index.

The caller presents an instruction with `inValid` high. The results appear on the registered outputs one clock later, with `outValid` high. Register-file reads, the memory access itself, condition evaluation and register-specified shift amounts are all outside this block.

Top module: `ldst_agen`

## Requirements
- R1: When instruction bit 25 is 0, the offset is instruction bits 11:0, zero-extended to the data width.
- R2: When bit 25 is 1, the offset is the offset register shifted by the amount in bits 11:7. The shift kind comes from bits 6:5: 00 is logical left, 01 is logical right, 10 is arithmetic right and 11 is rotate right.
- R3: An amount of 0 leaves a logical-left shift unchanged. With logical right it means a shift by 32, giving zero. With arithmetic right it means a shift by 32, filling every bit with the sign bit. With rotate right it means a one-bit rotate in which the incoming carry flag enters bit 31.
- R4: Bit 23 set adds the offset to the base; bit 23 clear subtracts it. The result wraps modulo 2^32.
- R5: With bit 24 set, the access address is the base combined with the offset. With bit 24 clear, the access address is the unmodified base.
- R6: The writeback value is always the base combined with the offset. Writeback is enabled when bit 24 is clear. When bit 24 is set, writeback is enabled only if bit 21 is set. For a pre-indexed access, the writeback value equals the access address.
- R7: `isLoad` follows bit 20 (1 = load), `isByte` follows bit 22 (1 = byte), and `baseIdx` is bits 19:16.
- R8: Results appear exactly one clock after `inValid`. When `inValid` is low, `outValid` and `wbEnable` go low on the next clock and all other outputs hold their values.
- R9: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Load/store instruction word |
| baseVal | input | XLEN | Base register value |
| offsetRegVal | input | XLEN | Offset register value |
| carryIn | input | 1 | Current carry flag, used by the rotate-with-extend case |
| outValid | output | 1 | Results below belong to an instruction |
| accessAddr | output | XLEN | Transfer address |
| wbValue | output | XLEN | Updated base value |
| wbEnable | output | 1 | Base register should be written |
| isLoad | output | 1 | 1 = load, 0 = store |
| isByte | output | 1 | 1 = byte, 0 = word |
| baseIdx | output | 4 | Base register index |

## Verification
Some rules are checked by the assertions on every cycle:
- the one-cycle timing;
- holding the outputs while idle;
- the unmodified base as the address for post-indexed transfers;
- the writeback-enable rule;
- a pre-indexed writeback value equal to the access address.

The arithmetic itself can only be shown by the bench scenarios. This covers each shift kind at every amount, the four zero-amount special cases with both carry values, and wrapping past zero and past 2^32. The bench sweeps these and compares each result against offsets it computes itself.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;

  // Fixed field positions in the instruction word.
  localparam int BIT_REG_OFF = 25;
  localparam int BIT_PRE     = 24;
  localparam int BIT_UP      = 23;
  localparam int BIT_BYTE    = 22;
  localparam int BIT_WB      = 21;
  localparam int BIT_LOAD    = 20;
  localparam int BASE_LSB    = 16;
  localparam int IMM_W       = 12;
  localparam int AMT_LSB     = 7;
  localparam int AMT_W       = 5;
  localparam int KIND_LSB    = 5;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shiftKind_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             useRegOffset;
    logic             addrFromSum;
    logic             addOffset;
    logic             writeBack;
    logic             loadXfer;
    logic             byteXfer;
    shiftKind_e       shiftKind;
    logic [AMT_W-1:0] shiftAmt;
    logic [3:0]       baseIdx;
    logic [IMM_W-1:0] immOffset;
  } agenCtrl_t;

endpackage

// File: rtl/ldst_agen_ctrl.sv
module ldst_agen_ctrl
  import ldst_agen_pkg::*;
(
  input  logic [31:0] instr,
  output agenCtrl_t   ctrl
);

  always_comb begin
    ctrl.useRegOffset = instr[BIT_REG_OFF];
    ctrl.addrFromSum  = instr[BIT_PRE];
    ctrl.addOffset    = instr[BIT_UP];
    ctrl.writeBack    = !instr[BIT_PRE] || instr[BIT_WB];
    ctrl.loadXfer     = instr[BIT_LOAD];
    ctrl.byteXfer     = instr[BIT_BYTE];
    ctrl.shiftKind    = shiftKind_e'(instr[KIND_LSB +: 2]);
    ctrl.shiftAmt     = instr[AMT_LSB +: AMT_W];
    ctrl.baseIdx      = instr[BASE_LSB +: 4];
    ctrl.immOffset    = instr[IMM_W-1:0];
  end

endmodule

// File: rtl/ldst_agen_shift.sv
module ldst_agen_shift
  import ldst_agen_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] opIn,
  input  shiftKind_e      kind,
  input  logic [SH_W-1:0] amt,
  input  logic            carryIn,
  output logic [XLEN-1:0] opOut
);

  logic            amtZero;
  logic [XLEN-1:0] lslRes, lsrRes, asrRes, rorRes;

  always_comb begin
    amtZero = (amt == '0);
    lslRes  = opIn << amt;
    // Zero amount encodes a full-width shift for the right shifts.
    lsrRes  = amtZero ? '0 : (opIn >> amt);
    asrRes  = amtZero ? {XLEN{opIn[XLEN-1]}} : XLEN'($signed(opIn) >>> amt);
    // Zero amount encodes a one-bit rotate through carry.
    rorRes  = amtZero ? {carryIn, opIn[XLEN-1:1]}
                      : ((opIn >> amt) | (opIn << (SH_W'(XLEN - 1) - amt + 1'b1)));
    unique case (kind)
      SH_LSL:  opOut = lslRes;
      SH_LSR:  opOut = lsrRes;
      SH_ASR:  opOut = asrRes;
      default: opOut = rorRes;
    endcase
  end

endmodule

// File: rtl/ldst_agen_dp.sv
module ldst_agen_dp
  import ldst_agen_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  agenCtrl_t       ctrl,
  input  logic [XLEN-1:0] baseVal,
  input  logic [XLEN-1:0] offsetRegVal,
  input  logic            carryIn,
  output logic [XLEN-1:0] accessAddr,
  output logic [XLEN-1:0] wbValue
);

  localparam int SH_W = $clog2(XLEN);

  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] sum;

  ldst_agen_shift #(.XLEN(XLEN)) shift_i (
    .opIn   (offsetRegVal),
    .kind   (ctrl.shiftKind),
    .amt    (SH_W'(ctrl.shiftAmt)),
    .carryIn(carryIn),
    .opOut  (shifted)
  );

  always_comb begin
    offset     = ctrl.useRegOffset ? shifted : XLEN'(ctrl.immOffset);
    sum        = ctrl.addOffset ? (baseVal + offset) : (baseVal - offset);
    accessAddr = ctrl.addrFromSum ? sum : baseVal;
    wbValue    = sum;
  end

endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_agen_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] baseVal,
  input  logic [XLEN-1:0] offsetRegVal,
  input  logic            carryIn,
  output logic            outValid,
  output logic [XLEN-1:0] accessAddr,
  output logic [XLEN-1:0] wbValue,
  output logic            wbEnable,
  output logic            isLoad,
  output logic            isByte,
  output logic [3:0]      baseIdx
);

  agenCtrl_t       ctrl;
  logic [XLEN-1:0] addrNext, wbNext;

  ldst_agen_ctrl ctrl_i (
    .instr(instr),
    .ctrl (ctrl)
  );

  ldst_agen_dp #(.XLEN(XLEN)) dp_i (
    .ctrl        (ctrl),
    .baseVal     (baseVal),
    .offsetRegVal(offsetRegVal),
    .carryIn     (carryIn),
    .accessAddr  (addrNext),
    .wbValue     (wbNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      wbEnable   <= 1'b0;
      accessAddr <= '0;
      wbValue    <= '0;
      isLoad     <= 1'b0;
      isByte     <= 1'b0;
      baseIdx    <= '0;
    end else begin
      outValid <= inValid;
      wbEnable <= inValid && ctrl.writeBack;
      if (inValid) begin
        accessAddr <= addrNext;
        wbValue    <= wbNext;
        isLoad     <= ctrl.loadXfer;
        isByte     <= ctrl.byteXfer;
        baseIdx    <= ctrl.baseIdx;
      end
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !wbEnable && $stable(accessAddr) && $stable(wbValue)
                  && $stable(baseIdx) && $stable(isLoad) && $stable(isByte)));

  assert_post_base_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !instr[BIT_PRE]) |=> (accessAddr == $past(baseVal)));

  assert_post_always_wb_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !instr[BIT_PRE]) |=> wbEnable);

  assert_pre_wb_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[BIT_PRE]) |=> (wbEnable == $past(instr[BIT_WB]) && wbValue == accessAddr));

  assert_fields_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (isLoad == $past(instr[BIT_LOAD]) && baseIdx == $past(instr[19:16])));

endmodule

// File: tb/ldst_agen_tb_top.sv
module ldst_agen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] baseVal = '0;
  logic [31:0] offsetRegVal = '0;
  logic        carryIn = 1'b0;
  logic        outValid, wbEnable, isLoad, isByte;
  logic [31:0] accessAddr, wbValue;
  logic [3:0]  baseIdx;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ldst_agen #(.XLEN(32)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .baseVal(baseVal), .offsetRegVal(offsetRegVal), .carryIn(carryIn),
    .outValid(outValid), .accessAddr(accessAddr), .wbValue(wbValue),
    .wbEnable(wbEnable), .isLoad(isLoad), .isByte(isByte), .baseIdx(baseIdx)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refShift(input logic [31:0] v, input int kind, input int amt, input logic c);
    logic [63:0] dbl;
    case (kind)
      0: return v << amt;
      1: return (amt == 0) ? 32'h0 : v >> amt;
      2: return (amt == 0) ? (v[31] ? 32'hFFFF_FFFF : 32'h0) : 32'($signed(v) >>> amt);
      default: begin
        if (amt == 0) return {c, v[31:1]};
        dbl = {v, v} >> amt;
        return dbl[31:0];
      end
    endcase
  endfunction

  // Called at a negative edge; returns at the next negative edge after checking.
  task automatic applyVec(input logic regOff, input logic pre, input logic up, input logic byteX,
                          input logic wb, input logic ld, input logic [3:0] rn, input logic [11:0] low,
                          input logic [31:0] base, input logic [31:0] rv, input logic c);
    logic [31:0] off, sum, expAddr;
    logic        expWb;
    instr        = {4'hE, 2'b01, regOff, pre, up, byteX, wb, ld, rn, 4'h0, low};
    baseVal      = base;
    offsetRegVal = rv;
    carryIn      = c;
    inValid      = 1'b1;
    if (regOff) off = refShift(rv, int'(low[6:5]), int'(low[11:7]), c);
    else        off = {20'h0, low};
    sum     = up ? base + off : base - off;
    expAddr = pre ? sum : base;
    expWb   = !pre || wb;
    @(negedge clk);
    vectors++;
    check("R8", "outValid", 32'(outValid), 32'd1);
    check(regOff ? "R2/R3" : "R1", "addr", accessAddr, expAddr);
    check("R4", "wbValue", wbValue, sum);
    check("R6", "wbEnable", 32'(wbEnable), 32'(expWb));
    check("R7", "isLoad", 32'(isLoad), 32'(ld));
    check("R7", "isByte", 32'(isByte), 32'(byteX));
    check("R7", "baseIdx", 32'(baseIdx), 32'(rn));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [3];
    logic [31:0] bases [2];
    logic [31:0] heldAddr, heldWb;
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hDEAD_BEEF;
    bases[0] = 32'hFFFF_FF00; bases[1] = 32'h0000_0010;

    // R9: reset state
    repeat (3) @(negedge clk);
    vectors++;
    check("R9", "outValid", 32'(outValid), 0);
    check("R9", "wbEnable", 32'(wbEnable), 0);
    check("R9", "accessAddr", accessAddr, 0);
    check("R9", "wbValue", wbValue, 0);
    check("R9", "baseIdx", 32'(baseIdx), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R4, R5, R6, R7: immediate form, every flag combination
    for (int f = 0; f < 32; f++) begin
      for (int b = 0; b < 2; b++) begin
        applyVec(1'b0, f[4], f[3], f[2], f[1], f[0], 4'(f + b), 12'(f * 131 + 12'hF00 * b),
                 bases[b], 32'h0, f[1]);
      end
    end
    applyVec(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 12'h020, 32'h0000_0010, 32'h0, 1'b0); // R4 wrap below zero
    applyVec(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9, 12'hFFF, 32'hFFFF_FF00, 32'h0, 1'b0); // R4 wrap past top

    // R2, R3: every shift kind and amount, both carry values
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 32; a++) begin
        for (int c = 0; c < 2; c++) begin
          for (int p = 0; p < 3; p++) begin
            applyVec(1'b1, (a + p) % 2 == 0, (a + k) % 3 != 0, p[0], c[0], k[0], 4'(a),
                     {5'(a), 2'(k), 1'b0, 4'(p)}, bases[(a + c) % 2], pats[p], c[0]);
          end
        end
      end
    end

    // R8: idle cycle drops valid/enable and holds the data outputs
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hA, {5'd4, 2'd0, 1'b0, 4'h0}, 32'h1000, 32'h10, 1'b0);
    heldAddr = accessAddr;
    heldWb   = wbValue;
    inValid  = 1'b0;
    baseVal  = 32'h5555_5555;
    @(negedge clk);
    vectors++;
    check("R8", "idle outValid", 32'(outValid), 0);
    check("R8", "idle wbEnable", 32'(wbEnable), 0);
    check("R8", "idle accessAddr", accessAddr, heldAddr);
    check("R8", "idle wbValue", wbValue, heldWb);
    check("R8", "idle baseIdx", 32'(baseIdx), 32'hA);
    check("R8", "idle isLoad", 32'(isLoad), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule